// File: doc/BRIEF.md
# BiSync Transparent Frame Receiver

This block sits behind a synchronous serial front end that already delivers byte-aligned 8-bit characters with a one-cycle valid strobe. It hunts for character sync on the SYN code (0x16). Once it has seen two or more SYN bytes followed by the DLE STX opener, it takes the rest of the stream as a transparent frame body. It strips the DLE escapes and writes the recovered payload bytes one at a time to a buffer write port.

The frame body ends at DLE ETX. Two CRC-16 trailer bytes follow, and the block checks them against its own accumulator. It then reports the outcome as a 3-bit status code with a one-cycle done pulse, together with the number of buffer bytes still unused, and goes back to hunting. The buffer is described by two inputs: a presence flag and a capacity. While the flag is low, the capacity is sampled. While it is high, each stored byte uses up one byte of that capacity. When no buffer is present, the block still follows the framing but stores nothing and feeds nothing into the CRC.

Top module: `bsr_rx`

## Requirements
- R1: A frame opens only after at least two SYN (0x16) bytes in a row, then DLE (0x10), then STX (0x02). A lone SYN followed by DLE STX opens nothing, and after any completion a new opener again needs the SYN pair.
- R2: If the byte after the opening DLE is anything other than STX, the frame ends with status 3.
- R3: Each body byte other than DLE is stored in arrival order. The byte is driven on wr_data with wr_en high in the cycle after it was accepted on rx_byte.
- R4: In the body, DLE DLE stores one 0x10 byte. DLE SYN stores nothing and leaves the CRC unchanged.
- R5: In the body, a DLE followed by any byte other than DLE, SYN or ETX (0x03) ends the frame with status 5.
- R6: The CRC-16 starts at zero and uses the reflected polynomial 0xA001, least significant bit first. It covers every stored byte plus the ETX. The trailer is sent low byte first, and a match gives status 0.
- R7: A trailer that differs from the accumulated CRC gives status 6.
- R8: If a body byte must be stored while the remaining room is zero, the frame ends at once with status 4 and room_left 0, and the block drops back to the SYN hunt.
- R9: While buf_present is low, nothing is written and nothing enters the CRC, but the framing is still followed to its end. If the buffer appears mid-frame, the rest of the frame is stored and the CRC covers only those bytes, plus the ETX.
- R10: When frame_done is high, room_left equals the sampled capacity minus the number of bytes stored in that frame.
- R11: frame_done is a single-cycle pulse, registered one cycle after the byte that ends the frame. frame_status keeps the last code until the next completion.
- R12: After reset, wr_en and frame_done are low and frame_status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_byte carries a new character this cycle |
| rx_byte | input | 8 | Received character |
| buf_present | input | 1 | A receive buffer is available |
| buf_cap | input | CNT_W | Buffer capacity in bytes, sampled while buf_present is low |
| wr_en | output | 1 | Store wr_data into the buffer |
| wr_data | output | 8 | Payload byte to store |
| frame_done | output | 1 | One-cycle completion pulse |
| frame_status | output | 3 | Completion code: 0 good, 3 no STX, 4 overflow, 5 bad escape, 6 CRC error |
| room_left | output | CNT_W | Unused buffer bytes, valid with frame_done |

## Verification
The assertions assume that buf_cap is stable whenever the buffer is present, and that it was valid in the cycle before buf_present rose. Under that assumption, the room count only moves down by one per store and only reloads when no buffer is present or when a frame has just completed. The bench changes the capacity only after dropping buf_present for two idle cycles. It raises buf_present mid-frame only on the same clock edge that delivers a body byte, so the byte sequence it expects to be stored is well defined.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam logic [7:0]  SYN_CH   = 8'h16;
    localparam logic [7:0]  DLE_CH   = 8'h10;
    localparam logic [7:0]  STX_CH   = 8'h02;
    localparam logic [7:0]  ETX_CH   = 8'h03;
    localparam logic [15:0] CRC_POLY = 16'hA001;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYN1,
        ST_SYNC,
        ST_WSTX,
        ST_BODY,
        ST_ESC,
        ST_CRCLO,
        ST_CRCHI
    } rx_state_e;

    typedef enum logic [2:0] {
        STAT_OK     = 3'd0,
        STAT_NOSTX  = 3'd3,
        STAT_OVF    = 3'd4,
        STAT_BADESC = 3'd5,
        STAT_BADCRC = 3'd6
    } rx_stat_e;

    typedef struct packed {
        logic       we;
        logic [7:0] data;
    } wr_beat_s;

endpackage

// File: rtl/bsr_crc16.sv
module bsr_crc16
    import bsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    localparam int BITS = 8;

    logic [15:0] stage [0:BITS];

    assign stage[0] = crc ^ {8'h00, din};

    generate
        for (genvar g = 0; g < BITS; g++) begin : g_bit
            assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ CRC_POLY)
                                            : (stage[g] >> 1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
        end else if (feed) begin
            crc <= stage[BITS];
        end
    end
endmodule

// File: rtl/bsr_room.sv
module bsr_room #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] cap,
    input  logic             take,
    output logic [CNT_W-1:0] room,
    output logic             empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            room <= '0;
        end else if (load) begin
            room <= cap;
        end else if (take) begin
            room <= room - 1'b1;
        end
    end

    assign empty = (room == '0);
endmodule

// File: rtl/bsr_rx.sv
module bsr_rx
    import bsr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             buf_present,
    input  logic [CNT_W-1:0] buf_cap,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             frame_done,
    output logic [2:0]       frame_status,
    output logic [CNT_W-1:0] room_left
);
    rx_state_e   st, st_n;
    rx_stat_e    code, stat_q;
    wr_beat_s    beat_q;
    logic        keep, take, fin, done_q;
    logic        crc_feed, crc_clr;
    logic        room_empty;
    logic [7:0]  crc_lo_q;
    logic [15:0] crc_acc;

    bsr_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .feed (crc_feed),
        .din  (rx_byte),
        .crc  (crc_acc)
    );

    bsr_room #(.CNT_W(CNT_W)) u_room (
        .clk   (clk),
        .rst   (rst),
        .load  (!buf_present || done_q),
        .cap   (buf_cap),
        .take  (take),
        .room  (room_left),
        .empty (room_empty)
    );

    always_comb begin
        st_n     = st;
        keep     = 1'b0;
        take     = 1'b0;
        fin      = 1'b0;
        code     = STAT_OK;
        crc_feed = 1'b0;
        crc_clr  = 1'b0;
        if (rx_valid) begin
            case (st)
                ST_HUNT:  if (rx_byte == SYN_CH) st_n = ST_SYN1;
                ST_SYN1:  st_n = (rx_byte == SYN_CH) ? ST_SYNC : ST_HUNT;
                ST_SYNC: begin
                    if (rx_byte == DLE_CH)      st_n = ST_WSTX;
                    else if (rx_byte != SYN_CH) st_n = ST_HUNT;
                end
                ST_WSTX: begin
                    if (rx_byte == STX_CH) begin
                        st_n    = ST_BODY;
                        crc_clr = 1'b1;
                    end else begin
                        st_n = ST_HUNT;
                        fin  = 1'b1;
                        code = STAT_NOSTX;
                    end
                end
                ST_BODY: begin
                    if (rx_byte == DLE_CH) st_n = ST_ESC;
                    else                   keep = 1'b1;
                end
                ST_ESC: begin
                    if (rx_byte == DLE_CH) begin
                        keep = 1'b1;
                        st_n = ST_BODY;
                    end else if (rx_byte == SYN_CH) begin
                        st_n = ST_BODY;
                    end else if (rx_byte == ETX_CH) begin
                        crc_feed = buf_present;
                        st_n     = ST_CRCLO;
                    end else begin
                        st_n = ST_HUNT;
                        fin  = 1'b1;
                        code = STAT_BADESC;
                    end
                end
                ST_CRCLO: st_n = ST_CRCHI;
                ST_CRCHI: begin
                    st_n = ST_HUNT;
                    fin  = 1'b1;
                    code = ({rx_byte, crc_lo_q} == crc_acc) ? STAT_OK : STAT_BADCRC;
                end
                default:  st_n = ST_HUNT;
            endcase

            if (keep && buf_present) begin
                if (room_empty) begin
                    st_n = ST_HUNT;
                    fin  = 1'b1;
                    code = STAT_OVF;
                end else begin
                    take     = 1'b1;
                    crc_feed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_HUNT;
            beat_q   <= '0;
            done_q   <= 1'b0;
            stat_q   <= STAT_OK;
            crc_lo_q <= '0;
        end else begin
            st        <= st_n;
            beat_q.we <= take;
            if (take) beat_q.data <= rx_byte;
            done_q    <= fin;
            if (fin) stat_q <= code;
            if (rx_valid && st == ST_CRCLO) crc_lo_q <= rx_byte;
        end
    end

    assign wr_en        = beat_q.we;
    assign wr_data      = beat_q.data;
    assign frame_done   = done_q;
    assign frame_status = stat_q;
endmodule

// File: rtl/bsr_rx_chk.sv
module bsr_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             buf_present,
    input logic             wr_en,
    input logic             frame_done,
    input logic [2:0]       frame_status,
    input logic [CNT_W-1:0] room_left
);
    // R3: a store always follows an accepted byte
    p_wr_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rx_valid));

    // R3: a stored byte never coincides with a completion
    p_wr_done_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && frame_done));

    // R9: nothing is stored without a buffer
    p_wr_needs_buf_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(buf_present));

    // R10: each store uses exactly one byte of room
    p_room_step_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (room_left == $past(room_left) - 1'b1));

    // R8: overflow reports an exhausted buffer
    p_ovf_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_done && frame_status == 3'd4) |-> (room_left == '0));

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7: only defined codes are reported
    p_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (frame_status inside {3'd0, 3'd3, 3'd4, 3'd5, 3'd6}));
endmodule

bind bsr_rx bsr_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .buf_present  (buf_present),
    .wr_en        (wr_en),
    .frame_done   (frame_done),
    .frame_status (frame_status),
    .room_left    (room_left)
);

// File: tb/tb_bsr_rx.sv
`timescale 1ns/1ps
module tb_bsr_rx;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_valid;
    logic [7:0]    rx_byte;
    logic          buf_present;
    logic [CW-1:0] buf_cap;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic          frame_done;
    logic [2:0]    frame_status;
    logic [CW-1:0] room_left;

    int total = 0;
    int bad   = 0;
    int dn    = 0;
    int st_seen, lf_seen;
    logic [7:0] got[$];
    logic [7:0] pay[$];

    always #4 clk = ~clk;

    bsr_rx #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .buf_present(buf_present), .buf_cap(buf_cap), .wr_en(wr_en),
        .wr_data(wr_data), .frame_done(frame_done),
        .frame_status(frame_status), .room_left(room_left)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) got.push_back(wr_data);
            if (frame_done) begin
                dn++;
                st_seen = int'(frame_status);
                lf_seen = int'(room_left);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 16'hA001) : (x >> 1);
        return x;
    endfunction

    task automatic put(input logic [7:0] b, input bit setp);
        @(negedge clk);
        if (setp) buf_present = 1'b1;
        rx_valid = 1'b1;
        rx_byte  = b;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'hFF;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_obs();
        got.delete();
        dn = 0;
        st_seen = -1;
        lf_seen = -1;
    endtask

    // pfrom: body index where the buffer appears (0 = from the start, large = never)
    // dsyn: body index before which a DLE SYN pair is inserted (-1 = none)
    task automatic run_frame(input int n, input int seed, input int cap,
                             input int pfrom, input int dsyn, input bit badc, input string tag);
        logic [7:0]  e[$];
        logic [15:0] crc;
        bit          ovf;
        int          exp_st, exp_lf;
        pay.delete();
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'(i * seed + 7 * n + seed);
            if ((i + seed) % 5 == 0) v = 8'h10;
            if ((i + seed) % 7 == 3) v = 8'h16;
            pay.push_back(v);
        end
        ovf = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i >= pfrom) begin
                if (e.size() == cap) begin ovf = 1'b1; break; end
                e.push_back(pay[i]);
            end
        end
        crc = 16'h0000;
        foreach (e[i]) crc = crc_step(crc, e[i]);
        if (pfrom <= n) crc = crc_step(crc, 8'h03);
        if (badc) crc = crc ^ 16'h0101;
        exp_st = ovf ? 4 : (badc ? 6 : 0);
        exp_lf = ovf ? 0 : cap - e.size();

        buf_present = 1'b0;
        buf_cap     = CW'(cap);
        idle(2);
        clear_obs();
        if (pfrom == 0) buf_present = 1'b1;
        for (int s = 0; s < 2 + (seed % 2); s++) put(8'h16, 1'b0);
        put(8'h10, 1'b0);
        put(8'h02, 1'b0);
        for (int i = 0; i < n; i++) begin
            if (i == dsyn) begin put(8'h10, 1'b0); put(8'h16, 1'b0); end
            if (pay[i] == 8'h10) begin
                put(8'h10, (i == pfrom) && (pfrom > 0));
                put(8'h10, 1'b0);
            end else begin
                put(pay[i], (i == pfrom) && (pfrom > 0));
            end
        end
        put(8'h10, 1'b0);
        put(8'h03, 1'b0);
        put(crc[7:0], 1'b0);
        put(crc[15:8], 1'b0);
        idle(4);

        chk(dn == 1, {tag, " R11 done count"}, dn, 1);
        chk(got.size() == e.size(), {tag, " R3 stored count"}, got.size(), e.size());
        for (int i = 0; i < e.size() && i < got.size(); i++)
            chk(got[i] == e[i], {tag, " R4 stored byte"}, int'(got[i]), int'(e[i]));
        chk(st_seen == exp_st, {tag, " R6 status"}, st_seen, exp_st);
        chk(lf_seen == exp_lf, {tag, " R10 room"}, lf_seen, exp_lf);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rx_valid = 1'b0;
        rx_byte = 8'hFF;
        buf_present = 1'b0;
        buf_cap = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_en == 1'b0, "R12 wr_en after reset", wr_en, 0);
        chk(frame_done == 1'b0, "R12 done after reset", frame_done, 0);
        chk(frame_status == 3'd0, "R12 status after reset", frame_status, 0);

        // R6/R3/R4: sweep payload lengths and patterns
        for (int n = 0; n <= 12; n++)
            for (int sd = 1; sd <= 5; sd += 2)
                run_frame(n, sd, 16, 0, -1, 1'b0, "sweep");

        // R4: DLE SYN pairs at several positions
        for (int k = 0; k < 6; k += 2) run_frame(6, 3, 16, 0, k, 1'b0, "dlesyn");

        // R7: corrupted trailer
        run_frame(4, 1, 16, 0, -1, 1'b1, "R7 badcrc");
        run_frame(0, 2, 16, 0, -1, 1'b1, "R7 badcrc empty");

        // R8: overflow, and exact fit
        run_frame(5, 1, 3, 0, -1, 1'b0, "R8 overflow");
        run_frame(1, 2, 0, 0, -1, 1'b0, "R8 zero room");
        run_frame(4, 2, 4, 0, -1, 1'b0, "R8 exact fit");
        run_frame(0, 1, 0, 0, -1, 1'b0, "R8 empty zero room");

        // R9: no buffer, and buffer arriving mid-frame
        run_frame(5, 1, 9, 1000, -1, 1'b0, "R9 no buffer");
        run_frame(6, 3, 16, 2, -1, 1'b0, "R9 mid-frame");
        run_frame(7, 1, 16, 4, -1, 1'b0, "R9 late buffer");

        // R2: byte after opening DLE is not STX
        buf_present = 1'b1;
        clear_obs();
        put(8'h16, 0); put(8'h16, 0); put(8'h10, 0); put(8'h41, 0);
        idle(3);
        chk(dn == 1, "R2 done count", dn, 1);
        chk(st_seen == 3, "R2 status", st_seen, 3);

        // R5: bad escape in body
        clear_obs();
        put(8'h16, 0); put(8'h16, 0); put(8'h10, 0); put(8'h02, 0);
        put(8'h55, 0); put(8'h10, 0); put(8'h07, 0);
        idle(3);
        chk(dn == 1, "R5 done count", dn, 1);
        chk(st_seen == 5, "R5 status", st_seen, 5);
        chk(got.size() == 1, "R5 stored count", got.size(), 1);

        // R1: lone SYN opens nothing; no opener without SYN pair after completion
        clear_obs();
        put(8'h16, 0); put(8'h41, 0); put(8'h16, 0); put(8'h10, 0); put(8'h02, 0);
        put(8'h55, 0); put(8'h66, 0); put(8'h10, 0); put(8'h03, 0);
        put(8'h00, 0); put(8'h00, 0);
        put(8'h10, 0); put(8'h02, 0); put(8'h55, 0); put(8'h10, 0); put(8'h03, 0);
        put(8'h00, 0); put(8'h00, 0);
        idle(3);
        chk(dn == 0, "R1 no frame without SYN pair", dn, 0);
        chk(got.size() == 0, "R1 nothing stored", got.size(), 0);

        run_frame(3, 5, 16, 0, -1, 1'b0, "R1 recovery");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule